// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor's load/store port and a slower word-wide memory. Every line holds one 32-bit word. The address picks one of 256 sets. The two ways of that set compare their stored tags against the request at the same time. A hit returns or absorbs the word with no memory traffic.

Stores write only the cache and mark the line as modified. On a miss, the controller picks a victim way. An empty way is taken first; otherwise the way that was not touched most recently is taken. If the victim holds modified data, that word is first sent back to memory. The missing word is then read in, and the original access is replayed.

The processor holds its request steady while the stall output is high. The access completes on the first clock edge at which stall is low. For a load, the returned word appears on the read-data output one cycle after that edge. The memory side keeps a request raised, with a steady address, until memory returns a one-cycle acknowledge.

Top module: `cache2w_wb`

## Requirements
- R1: After reset every line is invalid and no set has a preferred way. The first access to any address misses, and the stall output is low while no request is present.
- R2: Address bits [31:10] form the tag and bits [9:2] select the set, so the set equals the word address modulo 256. Bits [1:0] do not affect lookup.
- R3: A load hit keeps stall low, completes in its first cycle, and returns the stored word on the read-data output in the next cycle. It causes no memory transfer.
- R4: Two addresses with the same set and different tags can be resident together, and at most one way matches any lookup.
- R5: A store hit updates only the cache and marks the line modified. Any number of stores to a resident line cause no memory transfer.
- R6: A miss whose victim is clean or empty issues exactly one memory read, with write-enable 0, to {tag, set, 2'b00}. Stall stays high from miss detection until the replayed access completes.
- R7: A store miss allocates the line: it reads the word from memory, installs it clean, and then writes the store data into the cache without writing memory.
- R8: When the victim is valid and modified, one memory write of the victim's word to {victim tag, set, 2'b00} comes before the memory read of the missing word.
- R9: Each hit or fill marks the touched way as most recent. When both ways are valid, a miss replaces the other way.
- R10: A memory request keeps the request, write-enable, address and write data unchanged until the cycle in which acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, registered, valid the cycle after completion |
| cpu_stall | output | 1 | High while the current request cannot complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 32 | Refill data, valid with acknowledge |

## Verification
Two events can land on the same access: the eviction of a modified line and the allocation for a store miss. The bench provokes this by dirtying one way of a set, filling the other way, and then storing to a third tag in that set. It then judges the result at the memory port. The old word must be written to the victim's address before the new address is read. The new store data must stay out of memory until a later eviction carries it out.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cstate_t;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SETS   = 256,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              store_en,
  input  logic [DATA_W-1:0] store_data,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_dirty
);
  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  // state bits with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= 1'b0;
    end else if (store_en) begin
      dirty_q[wr_idx] <= 1'b1;
    end
  end

  // storage arrays, no reset so they map to RAM
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[wr_idx] <= fill_tag;
    if (fill_en || store_en)
      data_mem[wr_idx] <= fill_en ? fill_data : store_data;
  end

  always_comb begin
    rd_valid = valid_q[lk_idx];
    rd_dirty = dirty_q[lk_idx];
    rd_tag   = tag_mem[lk_idx];
    rd_data  = data_mem[lk_idx];
    hit      = rd_valid && (rd_tag == lk_tag);
  end

  logic [IDX_W-1:0] chk_idx;
  always_ff @(posedge clk) chk_idx <= wr_idx;

  // R7
  fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[chk_idx] && !dirty_q[chk_idx]);

  // R5
  store_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (store_en && !fill_en) |=> dirty_q[chk_idx] && valid_q[chk_idx]);
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             valid0,
  input  logic             valid1,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] touch_idx,
  output logic             victim
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (touch_en) lru_q[touch_idx] <= ~touch_way;
  end

  always_comb begin
    if (!valid0)      victim = 1'b0;
    else if (!valid1) victim = 1'b1;
    else              victim = lru_q[idx];
  end

  logic [IDX_W-1:0] chk_idx;
  logic             chk_way;
  always_ff @(posedge clk) begin
    chk_idx <= touch_idx;
    chk_way <= touch_way;
  end

  // R9
  lru_flip_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> lru_q[chk_idx] != chk_way);
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  localparam int OFF_W = ADDR_W - IDX_W - TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              hit,
  input  logic              victim_way,
  input  logic              victim_valid,
  input  logic              victim_dirty,
  input  logic [TAG_W-1:0]  victim_tag,
  input  logic [DATA_W-1:0] victim_data,
  input  logic              mem_ack,
  output cstate_t           state,
  output logic              fill_en,
  output logic              fill_way,
  output logic [IDX_W-1:0]  lat_idx,
  output logic [TAG_W-1:0]  lat_tag,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  cstate_t state_q;
  logic    vway_q;
  logic    miss;

  assign miss     = (state_q == ST_IDLE) && cpu_req && !hit;
  assign state    = state_q;
  assign fill_en  = (state_q == ST_FILL) && mem_ack;
  assign fill_way = vway_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      vway_q    <= 1'b0;
      lat_idx   <= '0;
      lat_tag   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss) begin
          lat_tag <= req_tag;
          lat_idx <= req_idx;
          vway_q  <= victim_way;
          mem_req <= 1'b1;
          if (victim_valid && victim_dirty) begin
            state_q   <= ST_WBACK;
            mem_we    <= 1'b1;
            mem_addr  <= {victim_tag, req_idx, {OFF_W{1'b0}}};
            mem_wdata <= victim_data;
          end else begin
            state_q  <= ST_FILL;
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, req_idx, {OFF_W{1'b0}}};
          end
        end
        ST_WBACK: if (mem_ack) begin
          state_q  <= ST_FILL;
          mem_we   <= 1'b0;
          mem_addr <= {lat_tag, lat_idx, {OFF_W{1'b0}}};
        end
        ST_FILL: if (mem_ack) begin
          state_q <= ST_IDLE;
          mem_req <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) &&
                              $stable(mem_we) && $stable(mem_wdata));

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WBACK && mem_ack) |=> (state_q == ST_FILL) && mem_req && !mem_we);

  // R6
  fill_is_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FILL && mem_req) |-> !mem_we);
endmodule

// File: rtl/cache2w_wb.sv
module cache2w_wb
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 256,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int WAYS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [OFF_W-1:0] unused_off;

  assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx    = cpu_addr[OFF_W +: IDX_W];
  assign unused_off = cpu_addr[OFF_W-1:0];

  logic [WAYS-1:0]   hit_w, vld_w, dty_w;
  logic [TAG_W-1:0]  tag_w [WAYS];
  logic [DATA_W-1:0] dat_w [WAYS];

  cstate_t          state;
  logic             fill_en, fill_way, victim, hit, complete;
  logic [IDX_W-1:0] lat_idx, wr_idx;
  logic [TAG_W-1:0] lat_tag;

  assign hit      = |hit_w;
  assign complete = (state == ST_IDLE) && cpu_req && hit;
  assign wr_idx   = fill_en ? lat_idx : req_idx;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache2w_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) i_way (
      .clk       (clk),
      .rst       (rst),
      .lk_idx    (req_idx),
      .lk_tag    (req_tag),
      .wr_idx    (wr_idx),
      .fill_en   (fill_en && (fill_way == 1'(w))),
      .fill_tag  (lat_tag),
      .fill_data (mem_rdata),
      .store_en  (complete && cpu_we && hit_w[w]),
      .store_data(cpu_wdata),
      .hit       (hit_w[w]),
      .rd_data   (dat_w[w]),
      .rd_tag    (tag_w[w]),
      .rd_valid  (vld_w[w]),
      .rd_dirty  (dty_w[w])
    );
  end

  cache2w_lru #(.SETS(SETS), .IDX_W(IDX_W)) i_lru (
    .clk      (clk),
    .rst      (rst),
    .idx      (req_idx),
    .valid0   (vld_w[0]),
    .valid1   (vld_w[1]),
    .touch_en (complete || fill_en),
    .touch_way(fill_en ? fill_way : hit_w[1]),
    .touch_idx(wr_idx),
    .victim   (victim)
  );

  cache2w_ctrl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cpu_req     (cpu_req),
    .req_tag     (req_tag),
    .req_idx     (req_idx),
    .hit         (hit),
    .victim_way  (victim),
    .victim_valid(vld_w[victim]),
    .victim_dirty(dty_w[victim]),
    .victim_tag  (tag_w[victim]),
    .victim_data (dat_w[victim]),
    .mem_ack     (mem_ack),
    .state       (state),
    .fill_en     (fill_en),
    .fill_way    (fill_way),
    .lat_idx     (lat_idx),
    .lat_tag     (lat_tag),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata)
  );

  assign cpu_stall = (state != ST_IDLE) || (cpu_req && !hit);

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (complete && !cpu_we) cpu_rdata <= hit_w[1] ? dat_w[1] : dat_w[0];
  end

  // R4
  one_way_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_w));

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_stall);
endmodule

// File: tb/test_cache2w_wb.sv
module test_cache2w_wb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  cache2w_wb i_cache2w_wb (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] bmem [4096];
  int          nrd = 0, nwr = 0, viol = 0, cnt = 0;
  logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
  logic [31:0] hold_addr = '0;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  initial for (int i = 0; i < 4096; i++) bmem[i] = init_val(32'(i) << 2);

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_req) begin
      if (cnt == 0) hold_addr <= mem_addr;
      else if (mem_addr != hold_addr) viol <= viol + 1;
      cnt <= cnt + 1;
      if (cnt == LAT - 1) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          bmem[mem_addr[13:2]] <= mem_wdata;
          nwr          <= nwr + 1;
          last_wr_addr <= mem_addr;
          last_wr_data <= mem_wdata;
        end else begin
          mem_rdata    <= bmem[mem_addr[13:2]];
          nrd          <= nrd + 1;
          last_rd_addr <= mem_addr;
        end
      end
    end
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    stalls = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (cpu_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    rd = cpu_rdata;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0000_0014, B = 32'h0000_0414, C = 32'h0000_0814;
  localparam logic [31:0] D = 32'h0000_0024, E = 32'h0000_0424, F = 32'h0000_0824;
  localparam logic [31:0] G = 32'h0000_0030;

  task automatic t_reset();
    logic [31:0] rd; int st, r0;
    @(negedge clk); #1;
    chk(cpu_stall == 1'b0, "R1 idle stall", 32'(cpu_stall), 0);
    r0 = nrd;
    access(1'b0, A, '0, rd, st);
    chk(nrd == r0 + 1, "R1 first access misses", 32'(nrd - r0), 1);
    chk(last_rd_addr == A, "R6 refill address", last_rd_addr, A);
    chk(rd == init_val(A), "R6 refill data", rd, init_val(A));
    chk(st >= LAT, "R6 stall held over miss", 32'(st), LAT);
  endtask

  task automatic t_hit();
    logic [31:0] rd; int st, r0, w0;
    r0 = nrd; w0 = nwr;
    access(1'b0, A, '0, rd, st);
    chk(st == 0, "R3 hit no stall", 32'(st), 0);
    chk(rd == init_val(A), "R3 hit data", rd, init_val(A));
    access(1'b0, A + 3, '0, rd, st);
    chk(rd == init_val(A) && st == 0, "R2 offset ignored", rd, init_val(A));
    chk(nrd == r0 && nwr == w0, "R3 no memory traffic", 32'(nrd - r0), 0);
  endtask

  task automatic t_two_ways();
    logic [31:0] rd; int st, r0;
    access(1'b0, B, '0, rd, st);
    chk(rd == init_val(B), "R2 same set other tag", rd, init_val(B));
    r0 = nrd;
    access(1'b0, A, '0, rd, st);
    chk(rd == init_val(A) && st == 0, "R4 way A resident", rd, init_val(A));
    access(1'b0, B, '0, rd, st);
    chk(rd == init_val(B) && st == 0, "R4 way B resident", rd, init_val(B));
    chk(nrd == r0, "R4 no refetch", 32'(nrd - r0), 0);
  endtask

  task automatic t_lru();
    logic [31:0] rd; int st, r0, w0;
    access(1'b0, A, '0, rd, st);
    r0 = nrd; w0 = nwr;
    access(1'b0, C, '0, rd, st);
    chk(rd == init_val(C) && nrd == r0 + 1 && nwr == w0, "R9 miss clean victim", rd, init_val(C));
    access(1'b0, A, '0, rd, st);
    chk(st == 0 && rd == init_val(A), "R9 recent way kept", 32'(st), 0);
    r0 = nrd;
    access(1'b0, B, '0, rd, st);
    chk(nrd == r0 + 1, "R9 old way evicted", 32'(nrd - r0), 1);
  endtask

  task automatic t_dirty();
    logic [31:0] rd; int st, r0, w0;
    access(1'b0, D, '0, rd, st);
    w0 = nwr; r0 = nrd;
    access(1'b1, D, 32'h1111_0001, rd, st);
    access(1'b1, D, 32'h2222_0002, rd, st);
    chk(nwr == w0 && nrd == r0, "R5 stores stay in cache", 32'(nwr - w0), 0);
    access(1'b0, D, '0, rd, st);
    chk(rd == 32'h2222_0002, "R5 store hit data", rd, 32'h2222_0002);
    access(1'b0, E, '0, rd, st);
    w0 = nwr; r0 = nrd;
    access(1'b1, F, 32'h3333_0003, rd, st);
    chk(nwr == w0 + 1, "R8 one write-back", 32'(nwr - w0), 1);
    chk(last_wr_addr == D, "R8 write-back address", last_wr_addr, D);
    chk(last_wr_data == 32'h2222_0002, "R8 write-back data", last_wr_data, 32'h2222_0002);
    chk(nrd == r0 + 1 && last_rd_addr == F, "R8 refill after write-back", last_rd_addr, F);
    chk(st >= 2 * LAT, "R8 stall covers both transfers", 32'(st), 2 * LAT);
    access(1'b0, F, '0, rd, st);
    chk(rd == 32'h3333_0003 && st == 0, "R7 allocated store data", rd, 32'h3333_0003);
    w0 = nwr;
    access(1'b0, D, '0, rd, st);
    chk(rd == 32'h2222_0002 && nwr == w0, "R8 reload from memory", rd, 32'h2222_0002);
    access(1'b0, E, '0, rd, st);
    chk(last_wr_addr == F && last_wr_data == 32'h3333_0003, "R8 later eviction", last_wr_data, 32'h3333_0003);
  endtask

  task automatic t_store_alloc();
    logic [31:0] rd; int st, r0, w0;
    r0 = nrd; w0 = nwr;
    access(1'b1, G, 32'hABCD_1234, rd, st);
    chk(nrd == r0 + 1 && nwr == w0, "R7 store miss reads only", 32'(nwr - w0), 0);
    access(1'b0, G, '0, rd, st);
    chk(rd == 32'hABCD_1234, "R7 store miss data", rd, 32'hABCD_1234);
    chk(bmem[G[13:2]] == init_val(G), "R7 memory untouched", bmem[G[13:2]], init_val(G));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_hit();
    t_two_ways();
    t_lru();
    t_dirty();
    t_store_alloc();
    chk(viol == 0, "R10 request stable", 32'(viol), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule